// File: doc/BRIEF.md
# Lookahead-Pipelined First-Order Recursive Filter

This block is a first-order recursive (IIR) filter with a fixed coefficient A, where |A| < 1. Its base law is y(n) = x(n) + A·y(n-1). The recurrence is unrolled by one step to y(n) = x(n) + A·x(n-1) + A²·y(n-2), so the feedback loop now spans two samples. That lets a register sit between the loop's multiply and its add.

A² is a constant worked out at elaboration. The A·x(n-1) term is formed outside the loop. Samples enter as signed integers with a valid strobe, one per clock at most. Gaps of any length are allowed. Each accepted sample produces exactly one signed result, one clock later than a single-register direct form would give it.

Inside one two-step update the intermediate y(n-1) is kept at full precision. Only the final sum is truncated (floor) to the output grid. The output therefore equals two steps of the direct recurrence with the middle step unrounded, starting from the previous truncated outputs. The coefficient is given as an integer `COEF` with `COEF_FRAC` fractional bits: A = COEF / 2^COEF_FRAC.

Top module: `lookahead_iir`

## Requirements
- R1: After reset, `outValid` is 0 and `outSample` is 0. All history is zero: y(-1) = y(-2) = 0 and x(-1) = 0. The first result after reset therefore equals the first input.
- R2: For accepted sample m, the result is y(m) = x(m) + floor(COEF·(x(m-1)·2^COEF_FRAC + COEF·y(m-2)) / 2^(2·COEF_FRAC)). Here y(m-2) is the result given two samples earlier, and floor rounds toward minus infinity.
- R3: For every input in the signed X_W-bit range, the result fits the signed (X_W+GUARD_W)-bit output. There is no wrap.
- R4: A sample accepted at clock edge t (`inValid` high) gives `outValid` high with its result on edge t+2.
- R5: `outValid` is never high unless a sample was accepted exactly two edges before.
- R6: While no result is being delivered, `outSample` holds its last result. Input data presented with `inValid` low has no effect on `outSample` or on later results.
- R7: Results are the same for any spacing of valid samples. This covers back-to-back samples, gaps of one or more cycles, and irregular patterns.
- R8: Asserting `rstN` low in mid-stream discards samples in flight and restarts with zero history, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe; high accepts `inSample` on this edge |
| inSample | input | X_W | Signed input sample |
| outValid | output | 1 | High for one cycle per result |
| outSample | output | X_W+GUARD_W | Signed filtered result, held between results |

## Verification
The hardest case to reach is the choice of y(m-2) when one sample follows another after exactly one clock. At that moment y(m-1) is still in the pipeline, and the operand is the latest committed output rather than the older one. With larger gaps the older one is used. The stimulus mixes back-to-back runs, strict alternation, every-third-cycle runs and a pseudo-random valid pattern, so both selections occur many times. Long runs of full-scale positive and negative input drive the output to its largest magnitude to test the width margin.

// File: rtl/lookahead_iir_pkg.sv
package lookahead_iir_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeSample;  // load input stage with a new sample
    logic commitOut;   // finish the add and update output history
    logic pickLatest;  // previous sample still in flight: y(m-2) is newest output
  } iirStrobes_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lookahead_iir_ctrl.sv
module lookahead_iir_ctrl
  import lookahead_iir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output iirStrobes_t strobes,
  output logic        outValid
);

  logic stageBusy;  // a sample sits in the multiply stage

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageBusy <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      stageBusy <= inValid;
      outValid  <= stageBusy;
    end
  end

  always_comb begin
    strobes.takeSample = inValid;
    strobes.commitOut  = stageBusy;
    strobes.pickLatest = stageBusy;
  end

  AST_IN_GIVES_OUT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);  // R4

  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));  // R5

endmodule

// File: rtl/lookahead_iir_dp.sv
module lookahead_iir_dp
  import lookahead_iir_pkg::*;
#(
  parameter int X_W       = 8,
  parameter int GUARD_W   = 3,
  parameter int COEF_W    = 10,
  parameter int COEF_FRAC = 8,
  parameter int COEF      = 192
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  iirStrobes_t            strobes,
  input  logic [X_W-1:0]         inSample,
  output logic [X_W+GUARD_W-1:0] outSample
);

  localparam int Y_W   = X_W + GUARD_W;
  localparam int SQ_W  = 2 * COEF_W;
  localparam int FF_W  = COEF_W + COEF_FRAC + X_W;
  localparam int FB_W  = SQ_W + Y_W;
  localparam int ACC_W = maxInt(FF_W, FB_W) + 1;
  localparam int SHIFT = 2 * COEF_FRAC;
  localparam logic signed [ACC_W-1:0] COEF_A  = ACC_W'(COEF);
  localparam logic signed [ACC_W-1:0] COEF_A2 = ACC_W'(COEF * COEF);

  logic signed [X_W-1:0]   xIn;
  logic signed [X_W-1:0]   xPrev;    // x(m-1), updated per accepted sample
  logic signed [X_W-1:0]   xStage;   // x(m) waiting for the add
  logic signed [ACC_W-1:0] ffStage;  // A*2^F*x(m-1)
  logic signed [ACC_W-1:0] fbStage;  // A^2*y(m-2)
  logic signed [Y_W-1:0]   yLast;
  logic signed [Y_W-1:0]   yOlder;

  logic signed [Y_W-1:0]   yBack2;
  logic signed [ACC_W-1:0] ffNext;
  logic signed [ACC_W-1:0] fbNext;
  logic signed [ACC_W-1:0] sumWide;
  logic signed [ACC_W-1:0] yWide;
  logic signed [Y_W-1:0]   yNext;

  assign xIn = inSample;

  // Feed-forward and loop multiplies, both registered before the add
  always_comb begin
    yBack2 = strobes.pickLatest ? yLast : yOlder;
    ffNext = (COEF_A * ACC_W'(xPrev)) <<< COEF_FRAC;
    fbNext = COEF_A2 * ACC_W'(yBack2);
  end

  // Add stage with a single floor truncation
  always_comb begin
    sumWide = ffStage + fbStage;
    yWide   = (sumWide >>> SHIFT) + ACC_W'(xStage);
    yNext   = yWide[Y_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPrev   <= '0;
      xStage  <= '0;
      ffStage <= '0;
      fbStage <= '0;
    end else if (strobes.takeSample) begin
      xPrev   <= xIn;
      xStage  <= xIn;
      ffStage <= ffNext;
      fbStage <= fbNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yLast  <= '0;
      yOlder <= '0;
    end else if (strobes.commitOut) begin
      yOlder <= yLast;
      yLast  <= yNext;
    end
  end

  assign outSample = yLast;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitOut |-> (yWide == ACC_W'(yNext)));  // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitOut |=> $stable(outSample));  // R6

endmodule

// File: rtl/lookahead_iir.sv
module lookahead_iir
  import lookahead_iir_pkg::*;
#(
  parameter int X_W       = 8,
  parameter int GUARD_W   = 3,
  parameter int COEF_W    = 10,
  parameter int COEF_FRAC = 8,
  parameter int COEF      = 192
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [X_W-1:0]         inSample,
  output logic                   outValid,
  output logic [X_W+GUARD_W-1:0] outSample
);

  iirStrobes_t strobes;

  lookahead_iir_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  lookahead_iir_dp #(
    .X_W       (X_W),
    .GUARD_W   (GUARD_W),
    .COEF_W    (COEF_W),
    .COEF_FRAC (COEF_FRAC),
    .COEF      (COEF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inSample  (inSample),
    .outSample (outSample)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (!outValid && outSample == '0));  // R1

endmodule

// File: tb/lookahead_iir_bench.sv
module lookahead_iir_bench;

  localparam int X_W       = 8;
  localparam int GUARD_W   = 3;
  localparam int COEF_W    = 10;
  localparam int COEF_FRAC = 8;
  localparam int COEF      = 192;
  localparam int Y_W       = X_W + GUARD_W;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           inValid = 1'b0;
  logic [X_W-1:0] inSample = '0;
  logic           outValid;
  logic [Y_W-1:0] outSample;

  always #5 clk = ~clk;

  lookahead_iir #(
    .X_W(X_W), .GUARD_W(GUARD_W), .COEF_W(COEF_W),
    .COEF_FRAC(COEF_FRAC), .COEF(COEF)
  ) u_lookahead_iir (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outSample(outSample)
  );

  int     checks = 0;
  int     fails  = 0;
  bit     done   = 1'b0;
  string  phaseTag = "R1";
  longint xm1 = 0, ym1 = 0, ym2 = 0;
  bit     e0v = 1'b0, e1v = 1'b0;
  longint e0y = 0, e1y = 0, lastY = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Two direct-form steps, middle one kept exact, final one floored
  function automatic longint model(input longint x);
    longint midExact, y;
    midExact = xm1 * (longint'(1) <<< COEF_FRAC) + longint'(COEF) * ym2;
    y = x + ((longint'(COEF) * midExact) >>> (2 * COEF_FRAC));
    ym2 = ym1;
    ym1 = y;
    xm1 = x;
    return y;
  endfunction

  function automatic void advLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  task automatic step(input bit v, input longint x);
    longint act;
    @(negedge clk);
    if (e1v) check(outValid === 1'b1, "R4 result strobe", longint'(outValid), 1);
    else     check(outValid === 1'b0, "R5 spurious strobe", longint'(outValid), 0);
    act = longint'($signed(outSample));
    if (e1v) begin
      check(act == e1y, {phaseTag, " result value"}, act, e1y);
      lastY = e1y;
    end else begin
      check(act == lastY, "R6 held result", act, lastY);
    end
    e1v = e0v;
    e1y = e0y;
    inValid  = v;
    inSample = X_W'(x);
    if (v) begin
      e0y = model(x);
      e0v = 1'b1;
      check((e0y < (longint'(1) <<< (Y_W-1))) && (e0y >= -(longint'(1) <<< (Y_W-1))),
            "R3 model range", e0y, 0);
    end else begin
      e0v = 1'b0;
    end
  endtask

  task automatic doReset(input string req);
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    xm1 = 0; ym1 = 0; ym2 = 0;
    e0v = 1'b0; e1v = 1'b0; lastY = 0;
    repeat (2) @(negedge clk);
    check(outValid === 1'b0 && outSample === '0, {req, " state in reset"},
          longint'($signed(outSample)), 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset("R1");
    @(negedge clk);
    check(outValid === 1'b0 && outSample === '0, "R1 state after release",
          longint'($signed(outSample)), 0);

    // R1: impulse from zero history, first result equals the input
    phaseTag = "R1";
    step(1'b1, 100);
    repeat (20) step(1'b1, 0);

    // R2: back-to-back pseudo-random samples
    phaseTag = "R2";
    repeat (200) begin
      advLfsr();
      step(1'b1, longint'($signed(lfsr[7:0])));
    end

    // R7: gap of one, gap of two, irregular spacing
    phaseTag = "R7";
    for (int i = 0; i < 60; i++) begin
      advLfsr();
      step(i % 2 == 0, longint'($signed(lfsr[7:0])));
    end
    for (int i = 0; i < 60; i++) begin
      advLfsr();
      step(i % 3 == 0, longint'($signed(lfsr[7:0])));
    end
    for (int i = 0; i < 300; i++) begin
      advLfsr();
      step(lfsr[3] ^ lfsr[9], longint'($signed(lfsr[15:8])));
    end

    // R3: full-scale runs to reach the largest magnitudes
    phaseTag = "R3";
    repeat (40) step(1'b1, 127);
    repeat (40) step(1'b1, -128);
    for (int i = 0; i < 30; i++) step(1'b1, (i % 2 == 0) ? 127 : -128);
    repeat (40) step(1'b1, 127);

    // R6: data moves while strobe is low; output and history must not
    phaseTag = "R6";
    for (int i = 0; i < 12; i++) step(1'b0, 55 - 9 * i);
    step(1'b1, 3);
    repeat (4) step(1'b1, 0);

    // R8: reset in mid-stream with samples in flight
    phaseTag = "R8";
    step(1'b1, 90);
    step(1'b1, -70);
    doReset("R8");
    step(1'b1, -60);
    repeat (10) step(1'b1, 0);
    repeat (3) step(1'b0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule